// File: doc/BRIEF.md
# Mirror-Decoded Multi-Granularity Bank Mapper

This block maps a 4 KB cartridge window onto larger internal ROM and RAM stores. The window is cut into sixteen 256-byte chunks. A mapping can cover an aligned run of 16, 8, 4, 2 or 1 chunks, so slots are 4 KB, 2 KB, 1 KB, 512 bytes or 256 bytes. The host configures the mapping by writing into the register range at the bottom of the address space. That range is normally owned by another chip, so the mapper only snoops those writes. Which mirror page of that range is written picks the slot size. Each slot has a 16-bit bank number, written as a low byte and a high byte, and a mode. The mode says whether the slot shows ROM or RAM and in which direction RAM can be used.

Every bank or mode write takes effect at once. It rewrites the table entries of the chunks the slot covers. The one exception is a chunk claimed by a smaller slot that was marked sticky: a larger mapping leaves it alone. This lets a small block of fixed RAM sit inside a window whose 4 KB bank keeps changing. Window reads are combinational from the address. Table updates and RAM writes happen on the rising clock edge of a write cycle. The block has no sequencing states. Its only state is the slot register file and the sixteen-entry chunk table. Both change in a single cycle, from reset or from a decoded register write.

Top module: `flex_bank_mapper`

## Requirements
- R1: After reset every chunk maps 4 KB ROM bank 0, all bank low and high bytes are zero, all modes are ROM and nothing is sticky.
- R2: A register write is decoded only when bus_we=1, A12=0, A7=0, A[10:8] is a page from 1 to 6 and A[5:0] is in $2F–$3F. Any other write, and any read, leaves the mapping unchanged.
- R3: Page 1 holds 4 KB slots, page 2 holds 2 KB, page 3 holds 1 KB, page 4 holds 512 B, and pages 5 and 6 hold 256 B slots 0–7 and 8–15. Slot n has its low byte at offset $30+2n and its high byte at $31+2n. Slots beyond the count for the size are ignored. Physical address = {high,low} × slot size + offset in slot. A write is visible from the next cycle.
- R4: Offset $2F in pages 1–5 is the mode register. Bits 3:0 are the slot, and a slot beyond the count is ignored. Bits 6:4 are the mode: 0 ROM, 1 RAM read/write, 2 RAM read-only, 3 RAM write-only, and 4–7 act as ROM. Bit 7 is sticky. $2F in page 6 is ignored.
- R5: Mapping a slot replaces every chunk it covers, including smaller mappings. A later smaller mapping replaces only its own chunks.
- R6: A chunk last mapped by a sticky slot keeps its mapping when a larger slot is mapped over it. A slot of the same or a smaller size still replaces it.
- R7: The same bank mapped into two slots shows the same bytes at both places, for RAM as well as ROM.
- R8: In read/write RAM mode the lower half of a slot is the write port and the upper half is the read port. Both halves address the same first half-slot of RAM, and reads from the lower half do not drive the bus.
- R9: A read-only slot ignores window writes. A write-only slot stores writes at any offset and never drives the bus.
- R10: bus_oe is 1 only on a window read (A12=1, bus_we=0) of a readable chunk. bus_oe is 0 for every address with A12=0 and on every write, and bus_rdata is 0 whenever bus_oe is 0.
- R11: The ROM byte at physical address p is p[7:0] ^ p[15:8] ^ $A5, after p is wrapped modulo 2^ROM_AW. RAM addresses wrap modulo 2^RAM_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Host address; A12 selects the cartridge window |
| bus_wdata | input | 8 | Host write data, snooped on every write cycle |
| bus_we | input | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_rdata | output | 8 | Byte driven onto the data bus |
| bus_oe | output | 1 | 1 when the mapper drives the data bus |

## Verification
Every chunk-table entry is visible at the ports through the next window read of its 256 bytes. A wrong base, size, mode or sticky flag therefore shows up as a wrong byte or a wrong bus_oe in the first cycle that reads that chunk after the faulty write. The reference model is compared on every clock, and reads are swept across all sixteen chunks after each configuration step. A fault is caught within one sweep of the write that caused it. RAM faults show up when the written data are read back through a second mode or a second slot.

// File: rtl/flex_map_pkg.sv
package flex_map_pkg;

    localparam int NCHUNK  = 16;
    localparam int NGRAN   = 5;
    localparam int BANK_W  = 16;
    localparam int PAGE_W  = BANK_W + 4;
    localparam int PHYS_W  = PAGE_W + 8;

    typedef enum logic [1:0] {
        MD_ROM    = 2'd0,
        MD_RAM_RW = 2'd1,
        MD_RAM_RO = 2'd2,
        MD_RAM_WO = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic [PAGE_W-1:0] base_page;
        logic [2:0]        gran;
        map_mode_e         mode;
        logic              sticky;
    } chunk_t;

    typedef struct packed {
        logic       valid;
        logic       is_mode;
        logic       is_hi;
        logic [2:0] gran;
        logic [3:0] slot;
        logic [7:0] data;
    } reg_cmd_t;

    function automatic logic [7:0] rom_byte(input logic [PHYS_W-1:0] p);
        return p[7:0] ^ p[15:8] ^ 8'hA5;
    endfunction

endpackage

// File: rtl/flex_reg_decode.sv
module flex_reg_decode
    import flex_map_pkg::*;
(
    input  logic       win,
    input  logic       a7,
    input  logic [2:0] page,
    input  logic [5:0] reg_off,
    input  logic       we,
    input  logic [7:0] wdata,
    output reg_cmd_t   cmd
);

    logic [2:0] gran;
    logic       page_ok;
    logic [3:0] slot_lim;
    logic [2:0] pair;

    always_comb begin
        gran    = 3'd0;
        page_ok = 1'b1;
        unique case (page)
            3'd1:    gran = 3'd0;
            3'd2:    gran = 3'd1;
            3'd3:    gran = 3'd2;
            3'd4:    gran = 3'd3;
            3'd5:    gran = 3'd4;
            3'd6:    gran = 3'd4;
            default: page_ok = 1'b0;
        endcase
        slot_lim = (gran >= 3'd3) ? 4'd8 : (4'd1 << gran);
        pair     = reg_off[3:1];

        cmd      = '0;
        cmd.gran = gran;
        cmd.data = wdata;
        if (we && !win && !a7 && page_ok && (reg_off >= 6'h2F)) begin
            if (reg_off == 6'h2F) begin
                cmd.is_mode = 1'b1;
                cmd.slot    = wdata[3:0];
                cmd.valid   = (page != 3'd6) &&
                              ({1'b0, wdata[3:0]} < (5'd1 << gran));
            end else begin
                cmd.is_hi = reg_off[0];
                cmd.slot  = {(page == 3'd6), pair};
                cmd.valid = ({1'b0, pair} < slot_lim);
            end
        end
    end

endmodule

// File: rtl/flex_chunk_table.sv
module flex_chunk_table
    import flex_map_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  reg_cmd_t                cmd,
    output chunk_t [NCHUNK-1:0]     tbl
);

    logic [7:0] lo_q  [NGRAN][NCHUNK];
    logic [7:0] hi_q  [NGRAN][NCHUNK];
    map_mode_e  md_q  [NGRAN][NCHUNK];
    logic       stk_q [NGRAN][NCHUNK];

    logic [2:0]        g;
    logic [3:0]        s;
    logic [2:0]        span_lg;
    logic [7:0]        lo_n;
    logic [7:0]        hi_n;
    map_mode_e         md_n;
    logic              stk_n;
    logic [PAGE_W-1:0] page_n;

    assign g       = cmd.gran;
    assign s       = cmd.slot;
    assign span_lg = 3'd4 - g;

    always_comb begin
        lo_n  = lo_q[g][s];
        hi_n  = hi_q[g][s];
        md_n  = md_q[g][s];
        stk_n = stk_q[g][s];
        if (cmd.is_mode) begin
            md_n  = cmd.data[6] ? MD_ROM : map_mode_e'(cmd.data[5:4]);
            stk_n = cmd.data[7];
        end else if (cmd.is_hi) begin
            hi_n = cmd.data;
        end else begin
            lo_n = cmd.data;
        end
        page_n = {4'h0, hi_n, lo_n} << span_lg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int gi = 0; gi < NGRAN; gi++) begin
                for (int si = 0; si < NCHUNK; si++) begin
                    lo_q[gi][si]  <= 8'h00;
                    hi_q[gi][si]  <= 8'h00;
                    md_q[gi][si]  <= MD_ROM;
                    stk_q[gi][si] <= 1'b0;
                end
            end
        end else if (cmd.valid) begin
            lo_q[g][s]  <= lo_n;
            hi_q[g][s]  <= hi_n;
            md_q[g][s]  <= md_n;
            stk_q[g][s] <= stk_n;
        end
    end

    for (genvar ci = 0; ci < NCHUNK; ci++) begin : g_chunk
        logic covered;
        logic shielded;
        assign covered  = ((4'(ci) >> span_lg) == s);
        assign shielded = tbl[ci].sticky && (tbl[ci].gran > g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[ci] <= '{base_page: '0, gran: 3'd0, mode: MD_ROM, sticky: 1'b0};
            end else if (cmd.valid && covered && !shielded) begin
                tbl[ci] <= '{base_page: page_n, gran: g, mode: md_n, sticky: stk_n};
            end
        end
    end

endmodule

// File: rtl/flex_access.sv
module flex_access
    import flex_map_pkg::*;
(
    input  logic              win,
    input  logic              we,
    input  logic [11:0]       woff,
    input  logic [PAGE_W-1:0] base_page,
    input  logic [2:0]        gran,
    input  map_mode_e         mode,
    output logic              oe,
    output logic              ram_we,
    output logic              src_rom,
    output logic [PHYS_W-1:0] phys
);

    logic [3:0]  cmask;
    logic [2:0]  span_lg;
    logic [3:0]  half_bit;
    logic [11:0] off_slot;
    logic [11:0] off_lin;
    logic        upper;
    logic        rd;

    always_comb begin
        span_lg  = 3'd4 - gran;
        cmask    = 4'hF >> gran;
        half_bit = 4'd7 + {1'b0, span_lg};
        off_slot = {woff[11:8] & cmask, woff[7:0]};
        upper    = off_slot[half_bit];
        off_lin  = (mode == MD_RAM_RW) ? (off_slot & ~(12'd1 << half_bit)) : off_slot;
        phys     = {base_page, 8'h00} | {{(PHYS_W-12){1'b0}}, off_lin};
        rd       = win && !we;
        src_rom  = (mode == MD_ROM);

        oe     = 1'b0;
        ram_we = 1'b0;
        unique case (mode)
            MD_ROM:    oe = rd;
            MD_RAM_RW: begin
                oe     = rd && upper;
                ram_we = win && we && !upper;
            end
            MD_RAM_RO: oe = rd;
            MD_RAM_WO: ram_we = win && we;
            default:   oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/flex_bank_mapper.sv
module flex_bank_mapper
    import flex_map_pkg::*;
#(
    parameter int ROM_AW = 16,
    parameter int RAM_AW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [12:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_we,
    output logic [7:0]  bus_rdata,
    output logic        bus_oe
);

    localparam int                RAM_DEPTH = 1 << RAM_AW;
    localparam logic [PHYS_W-1:0] ROM_MASK  = PHYS_W'((64'd1 << ROM_AW) - 64'd1);

    reg_cmd_t             cmd;
    chunk_t [NCHUNK-1:0]  tbl;
    chunk_t               cur;
    map_mode_e            cur_mode;
    logic                 ram_we;
    logic                 src_rom;
    logic [PHYS_W-1:0]    phys;
    logic [7:0]           ram_q [RAM_DEPTH];
    logic                 unused_bits;

    flex_reg_decode u_dec (
        .win     (bus_addr[12]),
        .a7      (bus_addr[7]),
        .page    (bus_addr[10:8]),
        .reg_off (bus_addr[5:0]),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .cmd     (cmd)
    );

    flex_chunk_table u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .tbl   (tbl)
    );

    assign cur      = tbl[bus_addr[11:8]];
    assign cur_mode = cur.mode;

    flex_access u_acc (
        .win       (bus_addr[12]),
        .we        (bus_we),
        .woff      (bus_addr[11:0]),
        .base_page (cur.base_page),
        .gran      (cur.gran),
        .mode      (cur_mode),
        .oe        (bus_oe),
        .ram_we    (ram_we),
        .src_rom   (src_rom),
        .phys      (phys)
    );

    always_ff @(posedge clk) begin
        if (rst_n && ram_we) begin
            ram_q[phys[RAM_AW-1:0]] <= bus_wdata;
        end
    end

    always_comb begin
        if (!bus_oe) begin
            bus_rdata = 8'h00;
        end else if (src_rom) begin
            bus_rdata = rom_byte(phys & ROM_MASK);
        end else begin
            bus_rdata = ram_q[phys[RAM_AW-1:0]];
        end
    end

    assign unused_bits = ^{bus_addr[6], cur.sticky, phys};

endmodule

module flex_map_checker
    import flex_map_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [12:0]         bus_addr,
    input logic                bus_we,
    input logic                bus_oe,
    input map_mode_e           cur_mode,
    input chunk_t [NCHUNK-1:0] tbl
);

    p_tia_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr[12] |-> !bus_oe);

    p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !bus_oe);

    p_wo_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MD_RAM_WO) |-> !bus_oe);

    p_rom_drives_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[12] && !bus_we && cur_mode == MD_ROM) |-> bus_oe);

    p_read_keeps_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(tbl));

    p_a7_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr[12] && bus_addr[7]) |=> $stable(tbl));

    p_window_write_keeps_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[12]) |=> $stable(tbl));

endmodule

bind flex_bank_mapper flex_map_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_oe   (bus_oe),
    .cur_mode (cur_mode),
    .tbl      (tbl)
);

// File: tb/test_flex_bank_mapper.sv
module test_flex_bank_mapper;

    logic        clk;
    logic        rst_n;
    logic [12:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic [7:0]  bus_rdata;
    logic        bus_oe;

    flex_bank_mapper i_flex_bank_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .bus_oe    (bus_oe)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 0;

    // reference model state
    int m_lo [5][16];
    int m_hi [5][16];
    int m_md [5][16];
    int m_st [5][16];
    int k_base [16];
    int k_gran [16];
    int k_md   [16];
    int k_st   [16];
    int m_ram  [2048];

    function automatic int rom_ref(int p);
        int q;
        q = p & 65535;
        return (q & 255) ^ ((q >> 8) & 255) ^ 165;
    endfunction

    task automatic model_reset();
        for (int g = 0; g < 5; g++)
            for (int s = 0; s < 16; s++) begin
                m_lo[g][s] = 0; m_hi[g][s] = 0; m_md[g][s] = 0; m_st[g][s] = 0;
            end
        for (int c = 0; c < 16; c++) begin
            k_base[c] = 0; k_gran[c] = 0; k_md[c] = 0; k_st[c] = 0;
        end
    endtask

    // expected oe and data (-1 = unknown data) for a window/TIA read
    task automatic model_read(input int a, output int eoe, output int edat);
        int c, cps, off, half, p;
        eoe = 0; edat = 0;
        if ((a & 4096) == 0) return;
        c    = (a >> 8) & 15;
        cps  = 16 >> k_gran[c];
        off  = (c % cps) * 256 + (a & 255);
        half = cps * 128;
        case (k_md[c])
            0: begin eoe = 1; edat = rom_ref(k_base[c] + off); end
            1: if (off >= half) begin eoe = 1; edat = m_ram[(k_base[c] + off - half) % 2048]; end
            2: begin eoe = 1; edat = m_ram[(k_base[c] + off) % 2048]; end
            default: eoe = 0;
        endcase
    endtask

    task automatic model_write(input int a, input int d);
        int c, cps, off, page, r, g, s, k, lim, bank;
        if ((a & 4096) != 0) begin
            c   = (a >> 8) & 15;
            cps = 16 >> k_gran[c];
            off = (c % cps) * 256 + (a & 255);
            if (k_md[c] == 3 || (k_md[c] == 1 && off < cps * 128))
                m_ram[(k_base[c] + off) % 2048] = d;
            return;
        end
        page = (a >> 8) & 7;
        r    = a & 63;
        if ((a & 128) != 0 || r < 47 || page == 0 || page == 7) return;
        g   = (page == 6) ? 4 : page - 1;
        lim = (1 << g) > 8 ? 8 : (1 << g);
        if (r == 47) begin
            if (page == 6) return;
            s = d & 15;
            if (s >= (1 << g)) return;
            m_md[g][s] = ((d >> 4) & 7) > 3 ? 0 : ((d >> 4) & 7);
            m_st[g][s] = (d >> 7) & 1;
        end else begin
            k = r - 48;
            s = k / 2;
            if (s >= lim) return;
            if (page == 6) s = s + 8;
            if (k % 2 == 1) m_hi[g][s] = d; else m_lo[g][s] = d;
        end
        cps  = 16 >> g;
        bank = m_hi[g][s] * 256 + m_lo[g][s];
        for (int j = 0; j < cps; j++) begin
            c = s * cps + j;
            if (k_st[c] != 0 && k_gran[c] > g) continue;
            k_base[c] = bank * cps * 256;
            k_gran[c] = g;
            k_md[c]   = m_md[g][s];
            k_st[c]   = m_st[g][s];
        end
    endtask

    task automatic op(input int a, input int d, input bit w, input string req);
        int eoe, edat;
        @(negedge clk);
        bus_addr  = 13'(a);
        bus_wdata = 8'(d);
        bus_we    = w;
        #2;
        if (w) begin eoe = 0; edat = 0; end
        else model_read(a, eoe, edat);
        n_vec++;
        if (int'(bus_oe) != eoe || (eoe == 1 && edat >= 0 && int'(bus_rdata) != edat)
            || (eoe == 0 && bus_rdata != 8'h00)) begin
            n_bad++;
            $display("FAIL %s addr=%h we=%0d oe=%0d/%0d data=%h/%h (actual/expected)",
                     req, a, w, bus_oe, eoe, bus_rdata, edat & 255);
        end
        @(posedge clk);
        #1;
        if (w) model_write(a, d);
    endtask

    task automatic sweep(input string req);
        for (int c = 0; c < 16; c++) begin
            op(4096 + c * 256 + 3, 0, 0, req);
            op(4096 + c * 256 + 131, 0, 0, req);
            op(4096 + c * 256 + 255, 0, 0, req);
        end
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) m_ram[i] = -1;
        model_reset();
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        sweep("R1");
        op(13'h1000, 0, 0, "R11");
        op(13'h1FFF, 0, 0, "R11");

        op(13'h0130, 3, 1, "R3");
        sweep("R3");
        op(13'h0131, 1, 1, "R3");
        sweep("R11");
        op(13'h0232, 5, 1, "R3");
        sweep("R3");

        op(13'h0638, 33, 1, "R5");
        sweep("R5");
        op(13'h0130, 2, 1, "R5");
        sweep("R5");

        // ignored register writes
        op(13'h01B0, 68, 1, "R2");
        op(13'h0120, 69, 1, "R2");
        op(13'h072F, 16, 1, "R2");
        op(13'h002F, 16, 1, "R2");
        op(13'h012F, 17, 1, "R4");
        op(13'h062F, 16, 1, "R4");
        op(13'h0236, 9, 1, "R3");
        sweep("R2");

        op(13'h0130, 0, 0, "R10");
        op(13'h0000, 0, 0, "R10");
        op(13'h0E3F, 0, 0, "R10");

        // sticky read/write 256-byte RAM at chunk 0
        op(13'h052F, 8'h90, 1, "R4");
        for (int i = 0; i < 128; i++) op(13'h1000 + i, (i * 7 + 1) & 255, 1, "R8");
        for (int i = 0; i < 128; i++) op(13'h1080 + i, 0, 0, "R8");
        op(13'h1000, 0, 0, "R8");
        op(13'h0130, 7, 1, "R6");
        sweep("R6");
        op(13'h052F, 8'h10, 1, "R6");
        op(13'h0130, 8, 1, "R6");
        sweep("R6");

        // read-only and write-only 1 KB slot 1
        op(13'h032F, 8'h21, 1, "R9");
        for (int i = 0; i < 16; i++) op(13'h1400 + i, 0, 0, "R9");
        op(13'h1400, 8'hEE, 1, "R9");
        op(13'h1400, 0, 0, "R9");
        op(13'h032F, 8'h31, 1, "R9");
        for (int i = 0; i < 16; i++) op(13'h1600 + i * 3, (i * 13 + 5) & 255, 1, "R9");
        op(13'h1600, 0, 0, "R9");
        op(13'h032F, 8'h21, 1, "R9");
        for (int i = 0; i < 48; i++) op(13'h1600 + i, 0, 0, "R9");

        // same bank in two 512-byte slots
        op(13'h0434, 9, 1, "R7");
        op(13'h043A, 9, 1, "R7");
        for (int i = 0; i < 32; i++) begin
            op(13'h1400 + i * 9, 0, 0, "R7");
            op(13'h1A00 + i * 9, 0, 0, "R7");
        end
        op(13'h042F, 8'h12, 1, "R7");
        op(13'h042F, 8'h15, 1, "R7");
        for (int i = 0; i < 32; i++) op(13'h1400 + i * 8, (i * 29 + 3) & 255, 1, "R7");
        for (int i = 0; i < 32; i++) op(13'h1B00 + i * 8, 0, 0, "R7");

        // mode codes 4-7 act as ROM
        op(13'h052F, 8'h53, 1, "R4");
        op(13'h1380, 0, 0, "R4");

        // 2 KB slot with high byte, then mixed sweep
        op(13'h0233, 2, 1, "R3");
        op(13'h0232, 4, 1, "R3");
        sweep("R5");

        done = 1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
        end
    end

    initial begin
        wait (done);
        #5;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule